// File: doc/BRIEF.md
# Prescaled Interval Down-Counter

This block is a programmable interval timer for a small controller. A free-running prescaler counts system clocks, and a three-bit ratio field picks which power-of-two tap becomes the counting tick. On every tick an eight-bit counter steps down by one. The cycle in which a decrement lands on zero sets a sticky interrupt flag. The counter then wraps to its maximum value and keeps counting without stopping.

Software reaches the timer through two registers on a simple strobe bus. Address 0 is the live count, and address 1 is the control word. Through the control word, software can clear the flag, mask the request, restart the prescaler phase and choose the ratio. The interrupt request output is the flag gated by the mask.

Top module: `interval_timer`

## Requirements
- R1: The prescaler is a 7-bit up-counter that advances on every clock. For ratio code k (0 to 7), a tick occurs in each cycle whose prescaler value has its low k bits all set. This gives a divide-by of 1, 2, 4, 8, 16, 32, 64 or 128, and code 0 ticks on every clock.
- R2: On each tick without a load, the counter decrements by one. The decrement from 0 gives 0xFF, so the counter counts freely after reaching zero.
- R3: With rd_en high and addr 0, rdata returns the live count combinationally, and reading does not alter counting. A write to addr 0 loads wdata, and counting continues from that value.
- R4: Writing the control word with bit 7 = 0 clears the flag. Writing it with bit 7 = 1 leaves the flag unchanged. The flag is never cleared by the timer itself.
- R5: irq is high exactly when the flag is set and the mask (control bit 6) is 0.
- R6: Writing the control word with bit 3 = 1 sets the prescaler to 0 on that clock edge. Bit 3 always reads back as 0.
- R7: After reset, the control word reads 0x44 (flag 0, mask 1, ratio 100), and the counter and prescaler are 0.
- R8: The control word reads as {flag, mask, 0, 0, 0, ratio[2:0]} from bit 7 down to bit 0. A control write updates the mask from bit 6 and the ratio from bits 2:0. rdata is 0 while rd_en is low.
- R9: When a count-register write and a tick fall in the same cycle, the written value is loaded and the tick is lost.
- R10: The flag sets when a tick decrements the counter from 1 to 0. If a flag-clearing control write falls in that same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; enables rdata |
| addr | input | 1 | Register select: 0 count, 1 control |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational |
| irq | output | 1 | Interrupt request, flag and not mask |

## Verification
The assertions assume that wr_en and rd_en are never high together. They also assume that the bus inputs are stable around the clock edge, because each property judges the write in a cycle by the values seen at the edge. The stimulus drives every bus input on the falling edge, with exactly one of the two strobes active in each cycle. It reads back the count or control register on every non-write cycle, so the reference model sees each state change at the register interface. The collision cases are lined up by counting the ticks from a known load at ratio code 0: a load and a control write land on a tick, and a clear lands on the decrement to zero.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DW = 8,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic [PW-1:0] pre_q;
  logic [DW-1:0] cnt_q;
  logic          flag_q, mask_q;
  logic [2:0]    ratio_q;

  wire cnt_wr = wr_en && !addr;
  wire ctl_wr = wr_en && addr;

  logic [PW-1:0] tap_mask;
  assign tap_mask = PW'((16'd1 << ratio_q) - 16'd1);

  wire tick     = (pre_q & tap_mask) == tap_mask;
  wire hit_zero = tick && !cnt_wr && (cnt_q == DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      mask_q  <= 1'b1;
      ratio_q <= 3'b100;
    end else begin
      pre_q <= (ctl_wr && wdata[3]) ? '0 : pre_q + PW'(1);
      if (cnt_wr)    cnt_q <= wdata;
      else if (tick) cnt_q <= cnt_q - DW'(1);
      if (hit_zero)                   flag_q <= 1'b1;
      else if (ctl_wr && !wdata[7])   flag_q <= 1'b0;
      if (ctl_wr) begin
        mask_q  <= wdata[6];
        ratio_q <= wdata[2:0];
      end
    end
  end

  wire [DW-1:0] ctrl_view = {flag_q, mask_q, {(DW-5){1'b0}}, ratio_q};

  assign rdata = !rd_en ? '0 : (addr ? ctrl_view : cnt_q);
  assign irq   = flag_q && !mask_q;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int DW = 8,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic          tick,
  input logic [PW-1:0] pre_q,
  input logic [DW-1:0] cnt_q,
  input logic          flag_q,
  input logic          mask_q
);
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && !addr) |-> cnt_q == $past(wdata));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tick && !(wr_en && !addr)) |-> cnt_q == $past(cnt_q));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flag_q) && !$past(wr_en && addr && !wdata[7])) |-> flag_q);

  p_prer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr && wdata[3]) |-> pre_q == '0);

  p_setwins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !(wr_en && !addr) && cnt_q == DW'(1)) |-> flag_q);

  p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !mask_q);

  p_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr) |-> rdata[5:3] == 3'b000);
endmodule

bind interval_timer interval_timer_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq), .tick(tick), .pre_q(pre_q),
  .cnt_q(cnt_q), .flag_q(flag_q), .mask_q(mask_q)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;

  always #4 clk = ~clk;

  interval_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  int checks = 0, fails = 0;
  int m_pre = 0, m_cnt = 0, m_flag = 0, m_mask = 1, m_ratio = 4;
  bit done = 0;

  function automatic int exp_read(bit a);
    if (a) return (m_flag << 7) | (m_mask << 6) | m_ratio;
    return m_cnt;
  endfunction

  task automatic check(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(bit we, bit a, int d);
    int per;
    bit tk, ld, zero;
    per  = 1 << m_ratio;
    tk   = (m_pre % per) == per - 1;
    ld   = we && !a;
    zero = tk && !ld && m_cnt == 1;
    m_pre = (we && a && d[3]) ? 0 : (m_pre + 1) % 128;
    if (ld) m_cnt = d;
    else if (tk) m_cnt = (m_cnt + 255) % 256;
    if (zero) m_flag = 1;
    else if (we && a && !d[7]) m_flag = 0;
    if (we && a) begin
      m_mask  = d[6];
      m_ratio = d & 7;
    end
  endtask

  task automatic step(bit we, bit a, int d, string req);
    wr_en = we; rd_en = !we; addr = a; wdata = 8'(d);
    #1;
    if (!we) check(int'(rdata), exp_read(a), req, a ? "ctrl read" : "count read");
    else check(int'(rdata), 0, "R8", "rdata idle");
    check(int'(irq), (m_flag && !m_mask) ? 1 : 0, "R5", "irq");
    @(posedge clk);
    model(we, a, d);
    @(negedge clk);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(1'b0, 1'(i % 2), 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 1, 0, "R7");
    step(0, 0, 0, "R7");
    // main countdown, free wrap, flag and irq
    step(1, 1, 8'h00, "R8");
    step(1, 0, 5, "R3");
    idle(10, "R2");
    // write 1 to flag keeps it, write 0 clears
    step(1, 1, 8'h80, "R4");
    idle(3, "R4");
    step(1, 1, 8'h00, "R4");
    idle(3, "R4");
    // masked request
    step(1, 1, 8'h40, "R5");
    step(1, 0, 3, "R5");
    idle(6, "R5");
    // every ratio code from a known prescaler phase
    for (int r = 1; r < 8; r++) begin
      step(1, 1, 8'h48 | r, "R1");
      step(1, 0, 3, "R1");
      idle(3 * (1 << r) + 4, "R1");
    end
    // prescaler restart mid-run
    step(1, 1, 8'h44, "R6");
    step(1, 0, 8'h20, "R6");
    idle(21, "R6");
    step(1, 1, 8'h4C, "R6");
    idle(40, "R6");
    // loads on consecutive ticking cycles
    step(1, 1, 8'h40, "R9");
    step(1, 0, 10, "R9");
    step(1, 0, 20, "R9");
    step(0, 0, 0, "R9");
    step(1, 0, 30, "R9");
    idle(2, "R9");
    // clear collides with the zero-reaching tick
    step(1, 1, 8'h00, "R10");
    step(1, 0, 3, "R10");
    step(0, 0, 0, "R10");
    step(0, 0, 0, "R10");
    step(1, 1, 8'h00, "R10");
    step(0, 1, 0, "R10");
    idle(4, "R10");
    // long wrap at the slowest ratio
    step(1, 1, 8'h07, "R2");
    step(1, 0, 2, "R2");
    idle(600, "R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule